// File: doc/BRIEF.md
# Successive-Approximation Converter Control Logic

This block is the digital half of a 12-bit successive-approximation converter. It watches five control lines: enable, active-low select, read-not-convert, byte address and bus width. Each line passes through a two-flop synchronizer and is then decoded into convert commands and read requests. A convert command clears the approximation register and puts the sample-and-hold into hold. The block then tries one bit at a time, MSB first, on the DAC code output. A single comparator bit decides whether each trial bit is kept. A conversion runs either all 12 bits or a short 8-bit cycle. The choice is made by the byte address present at the command.

After the last trial the block returns the sample-and-hold to sample mode. It keeps the busy flag high for a further settling window, and reads are already served during that window. The result goes onto a 12-line data bus with one output enable per line, which stands in for tri-state pads. The bus is either one 12-bit word or two bytes steered by the byte address. Low-byte reads put the four result LSBs on the bottom lines and zeros above them.

Stand-alone use ties enable and bus width high and select and address low. In that mode a falling read-not-convert line starts a conversion, and the bus is driven whenever that line is high.

Top module: `sar_conv_ctl`

## Requirements
- R1: A convert command is the rising of the condition (enable=1, select_n=0, rd_not_cv=0) seen after synchronization. With addr_i=0 at the command the busy flag stays high for 12*TRIAL_CYC+ACQ_CYC clocks. With addr_i=1 it stays high for 8*TRIAL_CYC+ACQ_CYC clocks.
- R2: While enable=0 or select_n=1, no conversion starts and every output enable stays low, whatever the other controls do.
- R3: The conversion length is set by addr_i as sampled at the command. Later changes of addr_i do not alter it.
- R4: Convert commands that arrive while busy is high are ignored and do not stretch the busy time. While hold_o is high all output enables are low, even when a read is requested.
- R5: The result is built MSB first. A trial bit is kept when comp_i=1 (the DAC code is at or below the input) and cleared otherwise. A full cycle yields the largest 12-bit code not above the input. A short cycle yields the largest such code on bits 11..4 and leaves bits 3..0 at zero.
- R6: hold_o is high exactly while bit trials run (12 or 8 times TRIAL_CYC clocks). During that time dac_code_o shows the bits decided so far plus one trial bit.
- R7: busy_o rises on the third clock edge after the command inputs are applied and stays high through the trials and ACQ_CYC more clocks. The final result can be read while busy_o is still high after hold_o has fallen.
- R8: A read (enable=1, select_n=0, rd_not_cv=1) with wide_i=1 drives all 12 lines with the result and enables all of them.
- R9: A read with wide_i=0 and addr_i=0 drives result bits 11..4 on lines 11..4, with only those lines enabled.
- R10: A read with wide_i=0 and addr_i=1 drives result bits 3..0 on lines 3..0 and zeros on lines 7..4, with lines 7..0 enabled and lines 11..8 disabled.
- R11: With enable=1, wide=1, select_n=0 and addr=0 held, a falling rd_not_cv starts a conversion. The bus is enabled whenever rd_not_cv is high and no trials run.
- R12: The bus outputs respond to a change of the control inputs on the second clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Chip enable, active high |
| select_n_i | input | 1 | Chip select, active low |
| rd_not_cv_i | input | 1 | High requests a read, low requests a convert |
| addr_i | input | 1 | Byte address at reads, short-cycle select at converts |
| wide_i | input | 1 | High: one 12-bit word; low: two bytes |
| comp_i | input | 1 | Comparator: 1 when the DAC code is at or below the held input |
| dac_code_o | output | 12 | Code driven to the DAC |
| hold_o | output | 1 | High puts the sample-and-hold into hold |
| busy_o | output | 1 | Conversion and settling in progress |
| data_o | output | 12 | Result bus data, zero on disabled lines |
| oe_o | output | 12 | Per-line output enable |

## Verification
On every cycle the assertions check four things. The latched length choice stays fixed while busy. Exactly one trial bit is active during trials, and no bits below it are set. The bus stays dark during trials. A low-byte read has the right enable pattern and zeroed middle nibble. Other behaviour shows only in the bench scenarios, checked against its per-clock model: the exact busy length for each cycle type, the conversion values for given inputs, ignored retriggers, the inhibit cases, reads during settling and the stand-alone pulse sequences.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

    localparam int RES_W  = 12;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_TRIAL  = 2'd1,
        PH_SETTLE = 2'd2
    } phase_e;

    typedef struct packed {
        logic en;
        logic sel_n;
        logic rdconv;
        logic addr;
        logic wide;
    } ctl_s;

    typedef struct packed {
        logic start;
        logic read;
    } cmd_s;

    typedef struct packed {
        logic [RES_W-1:0] data;
        logic [RES_W-1:0] oe;
    } bus_s;

    function automatic bus_s fmt_bus(input logic [RES_W-1:0] res,
                                     input logic wide,
                                     input logic addr);
        bus_s b;
        b = '0;
        if (wide) begin
            b.data = res;
            b.oe   = '1;
        end else if (!addr) begin
            b.data[RES_W-1:RES_W-BYTE_W] = res[RES_W-1:RES_W-BYTE_W];
            b.oe[RES_W-1:RES_W-BYTE_W]   = '1;
        end else begin
            b.data[NIB_W-1:0] = res[NIB_W-1:0];
            b.oe[BYTE_W-1:0]  = '1;
        end
        return b;
    endfunction

endpackage

// File: rtl/sarc_sync.sv
module sarc_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sarc_decode.sv
module sarc_decode
    import sarc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_s ctl_i,
    output cmd_s cmd_o
);
    logic conv_lvl;
    logic conv_prev_q;

    assign conv_lvl = ctl_i.en & ~ctl_i.sel_n & ~ctl_i.rdconv;

    always_ff @(posedge clk) begin
        if (rst) conv_prev_q <= 1'b0;
        else     conv_prev_q <= conv_lvl;
    end

    assign cmd_o.start = conv_lvl & ~conv_prev_q;
    assign cmd_o.read  = ctl_i.en & ~ctl_i.sel_n & ctl_i.rdconv;
endmodule

// File: rtl/sarc_engine.sv
module sarc_engine
    import sarc_pkg::*;
#(
    parameter int TRIAL_CYC = 4,
    parameter int ACQ_CYC   = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             short_i,
    input  logic             comp_i,
    output logic             busy_o,
    output logic             hold_o,
    output logic [RES_W-1:0] res_o,
    output logic [RES_W-1:0] dac_o
);
    localparam int TW = (TRIAL_CYC > 1) ? $clog2(TRIAL_CYC) : 1;
    localparam int AW = (ACQ_CYC > 1) ? $clog2(ACQ_CYC) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(TRIAL_CYC - 1);
    localparam logic [AW-1:0] A_LAST = AW'(ACQ_CYC - 1);

    phase_e           phase_q;
    logic [RES_W-1:0] mask_q;
    logic [RES_W-1:0] sar_q;
    logic             short_q;
    logic [TW-1:0]    tcnt_q;
    logic [AW-1:0]    acnt_q;
    logic             last_bit;

    assign last_bit = short_q ? mask_q[NIB_W] : mask_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            mask_q  <= '0;
            sar_q   <= '0;
            short_q <= 1'b0;
            tcnt_q  <= '0;
            acnt_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_TRIAL;
                        short_q <= short_i;
                        sar_q   <= '0;
                        mask_q  <= {1'b1, {(RES_W-1){1'b0}}};
                        tcnt_q  <= '0;
                    end
                end
                PH_TRIAL: begin
                    if (tcnt_q == T_LAST) begin
                        tcnt_q <= '0;
                        if (comp_i) sar_q <= sar_q | mask_q;
                        mask_q <= mask_q >> 1;
                        if (last_bit) begin
                            phase_q <= PH_SETTLE;
                            mask_q  <= '0;
                            acnt_q  <= '0;
                        end
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                PH_SETTLE: begin
                    if (acnt_q == A_LAST) phase_q <= PH_IDLE;
                    else                  acnt_q  <= acnt_q + 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy_o = (phase_q != PH_IDLE);
    assign hold_o = (phase_q == PH_TRIAL);
    assign res_o  = sar_q;
    assign dac_o  = sar_q | mask_q;

    // R3
    short_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |=> $stable(short_q));

    // R6
    one_trial_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TRIAL) |-> ($countones(mask_q) == 1));

    // R5
    below_trial_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TRIAL) |-> ((sar_q & (mask_q - RES_W'(1))) == '0));
endmodule

// File: rtl/sar_conv_ctl.sv
module sar_conv_ctl
    import sarc_pkg::*;
#(
    parameter int TRIAL_CYC   = 4,
    parameter int ACQ_CYC     = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              select_n_i,
    input  logic              rd_not_cv_i,
    input  logic              addr_i,
    input  logic              wide_i,
    input  logic              comp_i,
    output logic [RES_W-1:0]  dac_code_o,
    output logic              hold_o,
    output logic              busy_o,
    output logic [RES_W-1:0]  data_o,
    output logic [RES_W-1:0]  oe_o
);
    ctl_s             ctl_raw;
    ctl_s             ctl_s_q;
    logic [$bits(ctl_s)-1:0] sync_q;
    cmd_s             cmd;
    logic [RES_W-1:0] res;
    bus_s             fb;
    logic             show;

    assign ctl_raw = '{en: enable_i, sel_n: select_n_i, rdconv: rd_not_cv_i,
                       addr: addr_i, wide: wide_i};

    sarc_sync #(.W($bits(ctl_s)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ctl_raw),
        .q_o (sync_q)
    );

    assign ctl_s_q = sync_q;

    sarc_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .ctl_i (ctl_s_q),
        .cmd_o (cmd)
    );

    sarc_engine #(.TRIAL_CYC(TRIAL_CYC), .ACQ_CYC(ACQ_CYC)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start_i (cmd.start),
        .short_i (ctl_s_q.addr),
        .comp_i  (comp_i),
        .busy_o  (busy_o),
        .hold_o  (hold_o),
        .res_o   (res),
        .dac_o   (dac_code_o)
    );

    assign fb     = fmt_bus(res, ctl_s_q.wide, ctl_s_q.addr);
    assign show   = cmd.read & ~hold_o;
    assign data_o = show ? fb.data : '0;
    assign oe_o   = show ? fb.oe   : '0;

    // R4
    dark_in_trial_chk: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> (oe_o == '0));

    // R10
    low_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.read && !hold_o && !ctl_s_q.wide && ctl_s_q.addr)
            |-> (oe_o == 12'h0FF && data_o[7:4] == 4'h0));
endmodule

// File: tb/test_sar_conv_ctl.sv
`timescale 1ns/1ps
module test_sar_conv_ctl;
    localparam int TRIAL = 4;
    localparam int ACQ   = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, sel_n = 1'b1, rdcv = 1'b1, addr = 1'b0, wide = 1'b1;
    logic comp;
    logic [11:0] vin = 12'h000;
    logic [11:0] dac, data, oe;
    logic hold, busy;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    assign comp = (dac <= vin);

    sar_conv_ctl #(.TRIAL_CYC(TRIAL), .ACQ_CYC(ACQ), .SYNC_STAGES(2)) i_sar_conv_ctl (
        .clk(clk), .rst(rst), .enable_i(en), .select_n_i(sel_n), .rd_not_cv_i(rdcv),
        .addr_i(addr), .wide_i(wide), .comp_i(comp), .dac_code_o(dac),
        .hold_o(hold), .busy_o(busy), .data_o(data), .oe_o(oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, updated every clock
    logic [4:0]  p1 = '0, p2 = '0;   // {en, sel_n, rdcv, addr, wide}
    bit          m_prev, m_busy, m_short, cnd;
    int          m_conv, m_acq;
    logic [11:0] m_res, m_vin;

    always @(posedge clk) begin
        if (rst) begin
            p1 = '0; p2 = '0; m_prev = 0; m_busy = 0; m_short = 0;
            m_conv = 0; m_acq = 0; m_res = '0; m_vin = '0;
        end else begin
            cnd = p2[4] & ~p2[3] & ~p2[2];
            if (m_busy) begin
                if (m_conv > 0) begin
                    m_conv--;
                    if (m_conv == 0) m_res = m_short ? (m_vin & 12'hFF0) : m_vin;
                end else begin
                    m_acq--;
                    if (m_acq == 0) m_busy = 0;
                end
            end else if (cnd && !m_prev) begin
                m_busy  = 1;
                m_short = p2[1];
                m_conv  = (m_short ? 8 : 12) * TRIAL;
                m_acq   = ACQ;
                m_vin   = vin;
            end
            m_prev = cnd;
            p2 = p1;
            p1 = {en, sel_n, rdcv, addr, wide};
        end
    end

    always @(negedge clk) begin
        logic rd, cv;
        logic [11:0] ed, eo;
        if (!rst) begin
            rd = p2[4] & ~p2[3] & p2[2];
            cv = m_busy && (m_conv > 0);
            ed = '0; eo = '0;
            if (rd && !cv) begin
                if (p2[0]) begin ed = m_res; eo = 12'hFFF; end
                else if (!p2[1]) begin ed = m_res & 12'hFF0; eo = 12'hFF0; end
                else begin ed = {8'h00, m_res[3:0]}; eo = 12'h0FF; end
            end
            chk("R7 busy", busy, m_busy);
            chk("R6 hold", hold, cv);
            chk("R8 R9 R10 R12 data", data, ed);
            chk("R2 R4 R11 oe", oe, eo);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_conv(input logic [11:0] v, input logic sh, input bit poke,
                           input bit acq_rd, input int exp_cnt);
        int n, g, n0;
        bit did;
        n = 0; g = 0; n0 = 0; did = 0;
        rdcv = 1'b1; tick(3);
        vin = v; addr = sh; rdcv = 1'b0;
        @(negedge clk);
        while (!busy && g < 10) begin @(negedge clk); g++; end
        while (busy) begin
            n++;
            if (poke && n == 5) begin rdcv = 1'b1; addr = ~addr; end
            if (poke && n == 8) begin
                chk("R4 bus dark during trials", oe, 12'h000);
                rdcv = 1'b0;
            end
            if (acq_rd && !did && !hold) begin did = 1; n0 = n; rdcv = 1'b1; end
            if (acq_rd && did && n == n0 + 3) begin
                chk("R7 read while settling data", data, v);
                chk("R7 read while settling oe", oe, 12'hFFF);
            end
            @(negedge clk);
        end
        chk("R1 R3 R4 busy length", n, exp_cnt);
    endtask

    task automatic rd_chk(input logic w, input logic a, input logic [11:0] ed,
                          input logic [11:0] eo, input string tag);
        wide = w; addr = a; rdcv = 1'b1;
        tick(3);
        chk({tag, " data"}, data, ed);
        chk({tag, " oe"}, oe, eo);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog act=running exp=finished");
        report();
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(1);
        chk("R7 reset busy", busy, 0);
        chk("R6 reset hold", hold, 0);
        chk("R2 reset oe", oe, 0);

        en = 1'b1; sel_n = 1'b0; rdcv = 1'b1; wide = 1'b1;
        tick(3);
        // R1 R5 R7 full cycle, read while settling
        do_conv(12'hA5C, 1'b0, 0, 1, 12*TRIAL + ACQ);
        rd_chk(1'b1, 1'b0, 12'hA5C, 12'hFFF, "R8 word");
        rd_chk(1'b0, 1'b0, 12'hA50, 12'hFF0, "R9 high byte");
        rd_chk(1'b0, 1'b1, 12'h00C, 12'h0FF, "R10 low byte");

        // R3 R4 short cycle, addr flipped and retrigger mid-cycle
        wide = 1'b1;
        do_conv(12'h7E9, 1'b1, 1, 0, 8*TRIAL + ACQ);
        rd_chk(1'b1, 1'b0, 12'h7E0, 12'hFFF, "R5 R3 short result");

        // R5 extremes
        do_conv(12'hFFF, 1'b0, 0, 0, 12*TRIAL + ACQ);
        rd_chk(1'b1, 1'b0, 12'hFFF, 12'hFFF, "R5 full scale");
        do_conv(12'h000, 1'b0, 0, 0, 12*TRIAL + ACQ);
        rd_chk(1'b1, 1'b0, 12'h000, 12'hFFF, "R5 zero");
        do_conv(12'h001, 1'b1, 0, 0, 8*TRIAL + ACQ);
        rd_chk(1'b0, 1'b1, 12'h000, 12'h0FF, "R5 R10 short low nibble");

        // R2 inhibit
        rdcv = 1'b1; en = 1'b0; vin = 12'h555; tick(3);
        rdcv = 1'b0; tick(10);
        chk("R2 enable low no start", busy, 0);
        rdcv = 1'b1; en = 1'b1; sel_n = 1'b1; tick(3);
        chk("R2 deselected no read", oe, 0);
        rdcv = 1'b0; tick(10);
        chk("R2 deselected no start", busy, 0);
        rdcv = 1'b1; tick(2);
        sel_n = 1'b0; wide = 1'b1; addr = 1'b0; tick(3);
        chk("R2 old result kept", data, 12'h000);

        // R11 stand-alone pulses
        vin = 12'h3C7; rdcv = 1'b0;
        tick(3);
        chk("R11 falling starts", busy, 1);
        chk("R11 bus off low", oe, 0);
        while (busy) @(negedge clk);
        rdcv = 1'b1; tick(3);
        chk("R11 high enables data", data, 12'h3C7);
        chk("R11 high enables oe", oe, 12'hFFF);
        vin = 12'h81E; rdcv = 1'b0; tick(3);
        chk("R11 second start", busy, 1);
        chk("R11 bus dark", oe, 0);
        while (busy) @(negedge clk);
        rdcv = 1'b1; tick(3);
        chk("R11 second result", data, 12'h81E);

        tick(4);
        report();
        $finish;
    end
endmodule